// File: doc/BRIEF.md
# Dual-Slope Conversion Phase Sequencer

This block is the digital timing core of a dual-slope integrating converter. A single counter, shared by all phases, steps the converter through four analog configurations: auto-zero, signal integrate, reference de-integrate and zero-integrator. The block drives one switch-control output for each phase. During de-integrate it counts clocks until the comparator flips. It then latches the count, the sampled input polarity and an over-range flag, and it drives a STATUS line that brackets each conversion.

The sequencer is a five-state machine. `ST_AZ` is auto-zero: it waits, and in hold mode it parks. `ST_INT` is signal integrate. `ST_DE` is reference de-integrate. `ST_SETTLE` is the remainder of the de-integrate window after a zero crossing; the analog section is already back in its auto-zero configuration. `ST_ZI` is the zero-integrator phase.

The transitions are:
- `az_to_int`: the auto-zero count is spent and the sequencer is not parked.
- `int_to_de`: the integrate count is spent; the polarity is sampled on this edge.
- `de_cross`: the comparator differs from the polarity. The next state is settle, or auto-zero if the window is already full.
- `de_overrange`: the window is full with no crossing. The next state is zero-integrator.
- `settle_to_az`: the window is full, or the run input is low.
- `zi_to_az`: the integrator has returned to zero, or the zero-integrator limit is reached.

With the run input high the sequencer repeats a fixed-length cycle. With it low, the conversion in progress finishes and the machine stops in auto-zero until the run input rises again.

With `CNT_W` as the counter width, the lengths are: de-integrate window 2^CNT_W clocks (4096 by default), integrate half of that, zero-integrator limit a quarter of it, and auto-zero half of it. The full cycle is therefore 2^(CNT_W+1) clocks (8192 by default).

Top module: `dual_slope_sequencer`

## Requirements
- R1: After reset, only `ph_az_o` is high, `status_o` is 0 and all result outputs are 0. In every cycle, exactly one of the four phase outputs is high.
- R2: Integrate lasts exactly 2^(CNT_W-1) clocks. `res_pos_o` takes the value `cmp_i` had in the last integrate clock (1 = positive input).
- R3: De-integrate continues until `cmp_i` differs from the sampled polarity. `res_cnt_o` is the number of de-integrate clocks before the clock in which the difference is seen. De-integrate therefore lasts `res_cnt_o`+1 clocks, and `ph_az_o` is high immediately afterwards.
- R4: If no crossing is seen within 2^CNT_W de-integrate clocks, the latched result is `res_ovr_o`=1 with `res_cnt_o`=0 (the full-scale count modulo 2^CNT_W), and the zero-integrator phase follows at once.
- R5: The zero-integrator phase ends after the clock in which `cmp_i` differs from the polarity, or after 2^(CNT_W-2) clocks, whichever comes first. Auto-zero follows.
- R6: With `run_i` held high, integrate starts every 2^(CNT_W+1) clocks, whatever the reading and whether or not it is over-range.
- R7: `status_o` is high in every integrate clock and rises on the edge that starts integrate. It is still high just after the result is latched and falls half a clock later. While `status_o` is low, the result outputs do not change.
- R8: If `run_i` is low in any clock after the crossing, the sequencer leaves the rest of de-integrate and starts a fresh auto-zero. With `run_i` high again, integrate then begins 2^(CNT_W-1) clocks later.
- R9: With `run_i` low, the conversion in progress completes. The sequencer then parks in auto-zero, `HOLD_LEAD` clocks before integrate, after a minimum auto-zero of 2^(CNT_W-1)-`HOLD_LEAD` clocks. Integrate starts `HOLD_LEAD` clock edges after the first edge that sees `run_i` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_i | input | 1 | Comparator: 1 when the integrator output is above zero |
| run_i | input | 1 | 1 = free-running conversions, 0 = finish and hold |
| ph_az_o | output | 1 | Auto-zero switch control |
| ph_int_o | output | 1 | Signal-integrate switch control |
| ph_de_o | output | 1 | Reference de-integrate switch control |
| ph_zi_o | output | 1 | Zero-integrator switch control |
| res_cnt_o | output | CNT_W | Latched de-integrate count |
| res_pos_o | output | 1 | Latched polarity, 1 = positive |
| res_ovr_o | output | 1 | Latched over-range flag |
| status_o | output | 1 | Conversion busy / data-valid strobe |

## Verification
The assertions check, in every cycle, that exactly one phase control is active and that each integrate phase has its exact length. They also check that de-integrate and zero-integrator stay within their limits, that zero-integrator only runs after an over-range result, and that the result holds still while STATUS is low. Only the bench scenarios can show the numeric relation between the comparator flip time and the latched count for every count and both polarities, and the fixed free-running period. The same holds for the early exit from de-integrate, the parked auto-zero with its fixed lead to integrate, and the half-clock fall of STATUS.

// File: rtl/dss_pkg.sv
package dss_pkg;

    typedef enum logic [2:0] {
        ST_AZ     = 3'd0,
        ST_INT    = 3'd1,
        ST_DE     = 3'd2,
        ST_SETTLE = 3'd3,
        ST_ZI     = 3'd4
    } seq_state_t;

endpackage

// File: rtl/dss_fsm.sv
module dss_fsm
    import dss_pkg::*;
#(
    parameter int CNT_W     = 12,
    parameter int HOLD_LEAD = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmp_i,
    input  logic             run_i,
    output logic             ph_az_o,
    output logic             ph_int_o,
    output logic             ph_de_o,
    output logic             ph_zi_o,
    output logic             start_o,
    output logic             latch_o,
    output logic             over_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic             pol_o
);

    localparam int               HALF     = 1 << (CNT_W - 1);
    localparam int               QUART    = 1 << (CNT_W - 2);
    localparam logic [CNT_W-1:0] DE_LAST  = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] INT_LAST = CNT_W'(HALF - 1);
    localparam logic [CNT_W-1:0] AZ_LAST  = CNT_W'(HALF - 1);
    localparam logic [CNT_W-1:0] ZI_LAST  = CNT_W'(QUART - 1);
    localparam logic [CNT_W-1:0] PARK_AT  = CNT_W'(HALF - HOLD_LEAD);

    seq_state_t       st, st_n;
    logic [CNT_W-1:0] cnt, cnt_n;
    logic             pol_q;
    logic             crossed;

    assign crossed = (cmp_i != pol_q);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st    <= ST_AZ;
            cnt   <= '0;
            pol_q <= 1'b0;
        end else begin
            st  <= st_n;
            cnt <= cnt_n;
            if (st == ST_INT && cnt == INT_LAST) begin
                pol_q <= cmp_i;
            end
        end
    end

    // next state and outputs
    always_comb begin
        st_n    = st;
        cnt_n   = cnt + 1'b1;
        start_o = 1'b0;
        latch_o = 1'b0;
        over_o  = 1'b0;
        unique case (st)
            ST_AZ: begin
                if (cnt == PARK_AT && !run_i) begin
                    cnt_n = cnt;
                end else if (cnt == AZ_LAST) begin
                    st_n    = ST_INT;
                    cnt_n   = '0;
                    start_o = 1'b1;
                end
            end
            ST_INT: begin
                if (cnt == INT_LAST) begin
                    st_n  = ST_DE;
                    cnt_n = '0;
                end
            end
            ST_DE: begin
                if (crossed) begin
                    latch_o = 1'b1;
                    if (cnt == DE_LAST) begin
                        st_n  = ST_AZ;
                        cnt_n = '0;
                    end else begin
                        st_n = ST_SETTLE;
                    end
                end else if (cnt == DE_LAST) begin
                    latch_o = 1'b1;
                    over_o  = 1'b1;
                    st_n    = ST_ZI;
                    cnt_n   = '0;
                end
            end
            ST_SETTLE: begin
                if (!run_i || cnt == DE_LAST) begin
                    st_n  = ST_AZ;
                    cnt_n = '0;
                end
            end
            ST_ZI: begin
                if (crossed || cnt == ZI_LAST) begin
                    st_n = ST_AZ;
                end
            end
            default: begin
                st_n  = ST_AZ;
                cnt_n = '0;
            end
        endcase
        ph_az_o  = (st == ST_AZ) || (st == ST_SETTLE);
        ph_int_o = (st == ST_INT);
        ph_de_o  = (st == ST_DE);
        ph_zi_o  = (st == ST_ZI);
        cnt_o    = cnt;
        pol_o    = pol_q;
    end

endmodule

// File: rtl/dss_result.sv
module dss_result #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             latch_i,
    input  logic             over_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             pol_i,
    output logic [CNT_W-1:0] res_cnt_o,
    output logic             res_pos_o,
    output logic             res_ovr_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_cnt_o <= '0;
            res_pos_o <= 1'b0;
            res_ovr_o <= 1'b0;
        end else if (latch_i) begin
            res_cnt_o <= over_i ? '0 : cnt_i;
            res_pos_o <= pol_i;
            res_ovr_o <= over_i;
        end
    end

endmodule

// File: rtl/dss_status.sv
module dss_status (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic latch_i,
    output logic status_o
);

    logic busy_q;
    logic busy_half;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
        end else if (start_i) begin
            busy_q <= 1'b1;
        end else if (latch_i) begin
            busy_q <= 1'b0;
        end
    end

    // trailing copy, half a clock behind
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_half <= 1'b0;
        end else begin
            busy_half <= busy_q;
        end
    end

    assign status_o = busy_q | busy_half;

endmodule

// File: rtl/dual_slope_sequencer.sv
module dual_slope_sequencer #(
    parameter int CNT_W     = 12,
    parameter int HOLD_LEAD = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmp_i,
    input  logic             run_i,
    output logic             ph_az_o,
    output logic             ph_int_o,
    output logic             ph_de_o,
    output logic             ph_zi_o,
    output logic [CNT_W-1:0] res_cnt_o,
    output logic             res_pos_o,
    output logic             res_ovr_o,
    output logic             status_o
);

    logic             start_w;
    logic             latch_w;
    logic             over_w;
    logic [CNT_W-1:0] cnt_w;
    logic             pol_w;

    dss_fsm #(.CNT_W(CNT_W), .HOLD_LEAD(HOLD_LEAD)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmp_i    (cmp_i),
        .run_i    (run_i),
        .ph_az_o  (ph_az_o),
        .ph_int_o (ph_int_o),
        .ph_de_o  (ph_de_o),
        .ph_zi_o  (ph_zi_o),
        .start_o  (start_w),
        .latch_o  (latch_w),
        .over_o   (over_w),
        .cnt_o    (cnt_w),
        .pol_o    (pol_w)
    );

    dss_result #(.CNT_W(CNT_W)) u_result (
        .clk       (clk),
        .rst_n     (rst_n),
        .latch_i   (latch_w),
        .over_i    (over_w),
        .cnt_i     (cnt_w),
        .pol_i     (pol_w),
        .res_cnt_o (res_cnt_o),
        .res_pos_o (res_pos_o),
        .res_ovr_o (res_ovr_o)
    );

    dss_status u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_w),
        .latch_i  (latch_w),
        .status_o (status_o)
    );

endmodule

// File: rtl/dual_slope_sequencer_chk.sv
module dual_slope_sequencer_chk #(
    parameter int CNT_W     = 12,
    parameter int HOLD_LEAD = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ph_az_o,
    input logic             ph_int_o,
    input logic             ph_de_o,
    input logic             ph_zi_o,
    input logic [CNT_W-1:0] res_cnt_o,
    input logic             res_pos_o,
    input logic             res_ovr_o,
    input logic             status_o
);

    localparam int INT_LEN = 1 << (CNT_W - 1);
    localparam int DE_MAX  = 1 << CNT_W;
    localparam int ZI_MAX  = 1 << (CNT_W - 2);

    logic [31:0] int_run, de_run, zi_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            int_run <= '0;
            de_run  <= '0;
            zi_run  <= '0;
        end else begin
            int_run <= ph_int_o ? int_run + 1 : '0;
            de_run  <= ph_de_o  ? de_run + 1  : '0;
            zi_run  <= ph_zi_o  ? zi_run + 1  : '0;
        end
    end

    AST_ONE_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({ph_az_o, ph_int_o, ph_de_o, ph_zi_o}) == 1); // R1

    AST_INT_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ph_int_o) |-> int_run == INT_LEN); // R2

    AST_DE_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        ph_de_o |-> de_run < DE_MAX); // R3

    AST_ZI_NEEDS_OVR: assert property (@(posedge clk) disable iff (!rst_n)
        ph_zi_o |-> res_ovr_o); // R4

    AST_ZI_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        ph_zi_o |-> zi_run < ZI_MAX); // R5

    AST_BUSY_IN_INT: assert property (@(posedge clk) disable iff (!rst_n)
        ph_int_o |-> status_o); // R7

    AST_DATA_STILL: assert property (@(posedge clk) disable iff (!rst_n)
        !status_o |=> $stable({res_cnt_o, res_pos_o, res_ovr_o})); // R7

endmodule

bind dual_slope_sequencer dual_slope_sequencer_chk #(
    .CNT_W(CNT_W), .HOLD_LEAD(HOLD_LEAD)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ph_az_o   (ph_az_o),
    .ph_int_o  (ph_int_o),
    .ph_de_o   (ph_de_o),
    .ph_zi_o   (ph_zi_o),
    .res_cnt_o (res_cnt_o),
    .res_pos_o (res_pos_o),
    .res_ovr_o (res_ovr_o),
    .status_o  (status_o)
);

// File: tb/dual_slope_sequencer_test.sv
module dual_slope_sequencer_test;

    localparam int CLK_PERIOD = 10;
    localparam int CW         = 5;
    localparam int LEAD       = 7;
    localparam int DE_MAX     = 1 << CW;
    localparam int HALF       = 1 << (CW - 1);
    localparam int ZI_MAX     = 1 << (CW - 2);
    localparam int PERIOD     = 1 << (CW + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmp = 1'b0;
    logic          run = 1'b1;
    logic          ph_az, ph_int, ph_de, ph_zi;
    logic [CW-1:0] res_cnt;
    logic          res_pos, res_ovr, status;

    int  n_run = 0;
    int  n_fail = 0;
    int  cyc = 0;
    int  last_int = -1;
    int  onehot_bad = 0;
    bit  done = 0;

    // comparator model parameters
    logic m_pol = 1'b0;
    int   m_k = 0;
    int   m_z = 0;
    int   de_n = 0;
    int   zi_n = 0;

    dual_slope_sequencer #(.CNT_W(CW), .HOLD_LEAD(LEAD)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmp_i     (cmp),
        .run_i     (run),
        .ph_az_o   (ph_az),
        .ph_int_o  (ph_int),
        .ph_de_o   (ph_de),
        .ph_zi_o   (ph_zi),
        .res_cnt_o (res_cnt),
        .res_pos_o (res_pos),
        .res_ovr_o (res_ovr),
        .status_o  (status)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) cyc++;

    // comparator flips after m_k de-integrate clocks / m_z zero-integrator clocks
    always @(negedge clk) begin
        if ((ph_az + ph_int + ph_de + ph_zi) != 1 && rst_n) onehot_bad++;
        if (ph_de) begin
            cmp  = (de_n >= m_k) ? ~m_pol : m_pol;
            de_n = de_n + 1;
        end else begin
            de_n = 0;
        end
        if (ph_zi) begin
            cmp  = (zi_n >= m_z) ? ~m_pol : m_pol;
            zi_n = zi_n + 1;
        end else begin
            zi_n = 0;
        end
        if (!ph_de && !ph_zi) cmp = m_pol;
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wait_int_rise();
        do begin @(posedge clk); #1; end while (!ph_int);
    endtask

    task automatic conv(input logic pol, input int k, input int z, input bit per_chk);
        int nint;
        int nde;
        int nzi;
        int exp_cnt;
        int exp_ovr;
        wait_int_rise();
        chk("R7 status high at integrate start", status, 1);
        if (per_chk && last_int >= 0) chk("R6 free-run period", cyc - last_int, PERIOD);
        last_int = cyc;
        m_pol = pol; m_k = k; m_z = z;
        nint = 0;
        while (ph_int) begin nint++; @(posedge clk); #1; end
        chk("R2 integrate length", nint, HALF);
        nde = 0;
        while (ph_de) begin nde++; @(posedge clk); #1; end
        exp_ovr = (k >= DE_MAX) ? 1 : 0;
        exp_cnt = exp_ovr ? 0 : k;
        chk(exp_ovr ? "R4 overrange count" : "R3 latched count", int'(res_cnt), exp_cnt);
        chk("R2 latched polarity", res_pos, pol);
        chk("R4 overrange flag", res_ovr, exp_ovr);
        chk("R3 de-integrate clocks", nde, exp_ovr ? DE_MAX : k + 1);
        chk("R7 status still high after latch", status, 1);
        @(negedge clk); #1;
        chk("R7 status low half clock after latch", status, 0);
        if (exp_ovr) begin
            chk("R4 zero-integrator follows", ph_zi, 1);
            nzi = 0;
            while (ph_zi) begin nzi++; @(posedge clk); #1; end
            chk("R5 zero-integrator length", nzi, (z + 1 < ZI_MAX) ? z + 1 : ZI_MAX);
            chk("R5 auto-zero after zero-integrator", ph_az, 1);
        end else begin
            chk("R3 auto-zero after crossing", ph_az, 1);
        end
    endtask

    initial begin
        int n;
        int bad;
        logic [CW-1:0] held;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 reset phase az", ph_az, 1);
        chk("R1 reset other phases", ph_int | ph_de | ph_zi, 0);
        chk("R1 reset status", status, 0);
        chk("R1 reset result", int'(res_cnt) + res_pos + res_ovr, 0);

        // sweep all in-range counts, both polarities
        for (int p = 0; p < 2; p++) begin
            for (int k = 0; k < DE_MAX; k++) begin
                conv(logic'(p), k, 0, 1'b1);
            end
        end
        // overrange with every zero-integrator return time up to past the limit
        for (int z = 0; z < ZI_MAX + 2; z++) begin
            conv(logic'(z & 1), DE_MAX + 3, z, 1'b1);
        end
        conv(1'b1, 9, 0, 1'b1);

        // R9: hold mode parks after completing the conversion
        wait_int_rise();
        m_pol = 1'b1; m_k = 10;
        run = 1'b0;
        while (!ph_de) begin @(posedge clk); #1; end
        while (ph_de) begin @(posedge clk); #1; end
        chk("R9 conversion completes under hold", int'(res_cnt), 10);
        held = res_cnt;
        bad = 0;
        for (int i = 0; i < 100; i++) begin
            @(posedge clk); #1;
            if (!ph_az || ph_int || status || res_cnt != held) bad++;
        end
        chk("R9 parked in auto-zero", bad, 0);
        @(negedge clk);
        run = 1'b1;
        n = 0;
        do begin @(posedge clk); #1; n++; end while (!ph_int);
        chk("R9 lead from run high to integrate", n, LEAD);
        chk("R9 status rises with integrate", status, 1);

        // R8: run low after crossing cuts de-integrate short
        m_pol = 1'b0; m_k = 3;
        run = 1'b0;
        while (!ph_de) begin @(posedge clk); #1; end
        while (ph_de) begin @(posedge clk); #1; end
        chk("R8 count before early exit", int'(res_cnt), 3);
        @(posedge clk); #1;
        chk("R8 auto-zero after early exit", ph_az, 1);
        run = 1'b1;
        n = 0;
        do begin @(posedge clk); #1; n++; end while (!ph_int);
        chk("R8 fresh auto-zero length", n, HALF);

        chk("R1 one-hot phases throughout", onehot_bad, 0);
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            done = 1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule